// File: doc/BRIEF.md
# Six-Channel Serial DAC Code Register Front End

This block is the digital side of a six-channel, 8-bit digital-to-analog converter. A host drives three wires (serial data, a shift clock and a load strobe) plus a static device-address pin. Fifteen bits shifted in, least significant first, form one frame. A frame holds an 8-bit output code, a 3-bit channel number and a 4-bit device code. When the load strobe rises, the device code is compared with the address pin. If they match, the output code goes into the holding register of the numbered channel.

The six holding registers drive the converter ladders in parallel. Each ladder produces code/256 of the reference span, so code 255 gives 255/256 of full scale. Several devices can share the data, clock and strobe wires, because each frame names the device it is meant for. All serial inputs are asynchronous to the system clock and are synchronised inside the block. The analog supply monitor is represented by a digital power-fail input, which forces every channel to zero scale.

Top module: `dac6_serial_front`

## Requirements
- R1: Each synchronised rising edge of `ser_clk` shifts the synchronised `ser_data` level into a 15-bit frame register. The frame is least significant bit first, so the first bit sent ends up as frame bit 1.
- R2: Frame bits 1..8 are the output code, with bit 1 of weight 2^0 and bit 8 of weight 2^7. Bits 9..11 are the channel number, with bit 9 least significant. Bits 12..15 are the device code, with bit 12 least significant.
- R3: Channel numbers 1 to 6 write channel 1 to 6. Channel n appears on `ch_code_o[8n-1:8n-8]`. Channel numbers 0 and 7 write no channel.
- R4: A write happens only when frame bits 12, 13 and 14 are 0, 0 and 1, and frame bit 15 equals the synchronised `sel_pin` level. Any other frame changes no channel.
- R5: Each rising edge of `ser_strobe` performs at most one write. Holding the strobe high, or shifting new bits while it is high, writes nothing more.
- R6: A channel output takes its new value on the third rising `clk` edge after `ser_strobe` goes high (two synchroniser stages, then the holding register), and not earlier.
- R7: While `pwr_fail` is high, all six channels are 8'h00 from the next edge, and writes are blocked. A write falling in the same cycle as `pwr_fail` is discarded.
- R8: `rst_n` low at a `clk` edge clears all channels and the frame register. A strobe after reset with no new frame writes nothing.
- R9: When the shift edge and the strobe edge are detected in the same cycle, the write uses the frame as it was before that shift.
- R10: A write changes only the addressed channel. The other five keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail | input | 1 | Supply-fault indication, active high, synchronous |
| ser_data | input | 1 | Serial frame data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_strobe | input | 1 | Load strobe, asynchronous |
| sel_pin | input | 1 | Device-address pin level |
| ch_code_o | output | 48 | Six 8-bit channel codes, channel 1 in the low byte |

## Verification
Two events can fall in the same system-clock cycle. One is a shift edge together with a strobe edge. The other is a strobe edge together with a power-fail pulse. For the first, the bench raises `ser_clk` and `ser_strobe` at the same instant, so both edges are detected together. The addressed channel must then hold the code of the complete frame, not the shifted one. For the second, the bench asserts `pwr_fail` for exactly the cycle in which the strobe edge is detected. All six channels must read zero at that point, and they must stay zero after the strobe is released.

// File: rtl/dsf_pkg.sv
// Shared widths and the frame layout of the serial DAC front end.
// Assumes: the frame is 15 bits, least significant bit first on the wire.
package dsf_pkg;
    localparam int CODE_W  = 8;
    localparam int CHAN_W  = 3;
    localparam int DEV_W   = 4;
    localparam int FRAME_W = CODE_W + CHAN_W + DEV_W;
    localparam int N_CH    = 6;
    localparam int SYNC_STAGES = 2;
    // Lower three device-code bits must read 0,0,1 (first bit sent is bit 0)
    localparam logic [DEV_W-2:0] DEV_FIXED = 3'b100;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [CHAN_W-1:0] chan;
        code_t             code;
    } frame_t;
endpackage

// File: rtl/dsf_sync.sv
// Multi-stage synchroniser for a vector of asynchronous levels.
// Assumes: every bit is sampled independently; all outputs share the same delay.
module dsf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] pipe [STAGES];

    // Clock the raw levels through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= async_i;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign level_o = pipe[STAGES-1];
endmodule

// File: rtl/dsf_edge.sv
// Rising-edge detector on already-synchronised levels: one-cycle pulse per edge.
// Assumes: inputs are synchronous to clk.
module dsf_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember the previous level of each input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/dsf_shift.sv
// Frame shift register: on each shift pulse the new bit enters at the top,
// so the first bit sent ends at bit 0 after a full frame.
// Assumes: shift_i is a single-cycle pulse per serial clock edge.
module dsf_shift #(
    parameter int FRAME_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);
    // Shift right, new bit in at the most significant end
    always_ff @(posedge clk) begin
        if (!rst_n)       frame_o <= '0;
        else if (shift_i) frame_o <= {bit_i, frame_o[FRAME_W-1:1]};
    end
endmodule

// File: rtl/dsf_decode.sv
// Device-code comparator and channel decoder: produces a one-hot write enable.
// Assumes: channel numbers start at 1; numbers with no channel write nothing.
module dsf_decode
    import dsf_pkg::*;
#(
    parameter int NCH = N_CH
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               pin_i,
    input  logic               load_i,
    input  logic               block_i,
    output logic [NCH-1:0]     wr_en_o
);
    frame_t f;
    logic   dev_ok;
    logic   go;

    assign f = frame_t'(frame_i);

    // Fixed low bits plus the top bit matching the address pin
    always_comb begin
        dev_ok = (f.dev[DEV_W-2:0] == DEV_FIXED) && (f.dev[DEV_W-1] == pin_i);
        go     = load_i && dev_ok && !block_i;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign wr_en_o[i] = go && (f.chan == CHAN_W'(i + 1));
    end
endmodule

// File: rtl/dsf_bank.sv
// Six holding registers, written one at a time, cleared together on fault.
// Assumes: wr_en_i is at most one-hot.
module dsf_bank
    import dsf_pkg::*;
#(
    parameter int NCH = N_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [NCH-1:0]      wr_en_i,
    input  code_t               code_i,
    output logic [NCH*CODE_W-1:0] ch_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        code_t hold_q;
        // Hold the channel code; clear on reset or supply fault
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) hold_q <= '0;
            else if (wr_en_i[i]) hold_q <= code_i;
        end
        assign ch_o[i*CODE_W +: CODE_W] = hold_q;
    end
endmodule

// File: rtl/dac6_serial_front.sv
// Top level: synchronises the serial wires, assembles frames and loads the
// addressed channel on each strobe rising edge.
// Assumes: the serial wires are slower than several clk cycles per phase.
module dac6_serial_front
    import dsf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_fail,
    input  logic                   ser_data,
    input  logic                   ser_clk,
    input  logic                   ser_strobe,
    input  logic                   sel_pin,
    output logic [N_CH*CODE_W-1:0] ch_code_o
);
    logic [3:0]         lvl;
    logic [1:0]         rise;
    logic               data_s, sclk_s, strb_s, pin_s;
    logic               shift_rise, strb_rise;
    logic [FRAME_W-1:0] frame_q;
    logic [N_CH-1:0]    wr_en;
    frame_t             fr;

    dsf_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({sel_pin, ser_strobe, ser_clk, ser_data}),
        .level_o(lvl)
    );
    assign {pin_s, strb_s, sclk_s, data_s} = lvl;

    dsf_edge #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .level_i({strb_s, sclk_s}),
        .rise_o(rise)
    );
    assign {strb_rise, shift_rise} = rise;

    dsf_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_i(shift_rise), .bit_i(data_s),
        .frame_o(frame_q)
    );

    dsf_decode #(.NCH(N_CH)) u_dec (
        .frame_i(frame_q), .pin_i(pin_s),
        .load_i(strb_rise), .block_i(pwr_fail),
        .wr_en_o(wr_en)
    );

    assign fr = frame_t'(frame_q);

    dsf_bank #(.NCH(N_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr_i(pwr_fail),
        .wr_en_i(wr_en), .code_i(fr.code),
        .ch_o(ch_code_o)
    );
endmodule

// File: rtl/dsf_checker.sv
// Temporal checks on the front end, attached by bind.
module dsf_checker
    import dsf_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwr_fail,
    input logic [N_CH*CODE_W-1:0] ch_code_o,
    input logic [N_CH-1:0]        wr_en,
    input logic [FRAME_W-1:0]     frame_q,
    input logic                   strb_rise,
    input logic                   pin_s
);
    // R7: fault clears all channels on the next edge
    p_fault_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (ch_code_o == '0));

    // R5: at most one channel written per cycle, only on a strobe edge
    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en) && ((wr_en != '0) -> strb_rise));

    // R4: a write implies the device code matched the pin
    p_dev_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> (frame_q[13:11] == DEV_FIXED && frame_q[14] == pin_s));

    // R10: with no write and no fault, nothing changes
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0 && !pwr_fail) |=> $stable(ch_code_o));

    for (genvar i = 0; i < N_CH; i++) begin : g_val
        // R3: written channel takes the frame code
        p_write_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[i] && !pwr_fail) |=>
                (ch_code_o[i*CODE_W +: CODE_W] == $past(frame_q[CODE_W-1:0])));
    end
endmodule

bind dac6_serial_front dsf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ch_code_o(ch_code_o),
    .wr_en(wr_en), .frame_q(frame_q), .strb_rise(strb_rise), .pin_s(pin_s)
);

// File: tb/sim_dac6_serial_front.sv
module sim_dac6_serial_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_strobe = 1'b0;
    logic        sel_pin = 1'b0;
    logic [47:0] ch_code_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    logic [7:0] model [1:6];

    always #2 clk = ~clk;

    dac6_serial_front u0 (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_strobe(ser_strobe), .sel_pin(sel_pin),
        .ch_code_o(ch_code_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=still running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input int ch, input logic [7:0] exp);
        logic [7:0] act;
        act = ch_code_o[ch*8-1 -: 8];
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d act=%02h exp=%02h", req, ch, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 1; c <= 6; c++) check8(req, c, model[c]);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;   tick(3);
        ser_clk = 1'b1; tick(3);
        ser_clk = 1'b0; tick(3);
    endtask

    // Frame: {dev[3:0], chan[2:0], code[7:0]}, bit 0 sent first (R1, R2)
    task automatic send_frame(input logic [3:0] dev, input logic [2:0] ch,
                              input logic [7:0] code);
        logic [14:0] f;
        f = {dev, ch, code};
        for (int i = 0; i < 15; i++) send_bit(f[i]);
    endtask

    task automatic pulse_strobe();
        ser_strobe = 1'b1; tick(4);
        ser_strobe = 1'b0; tick(4);
    endtask

    // Reference rule from R3/R4
    task automatic model_write(input logic [3:0] dev, input logic [2:0] ch,
                               input logic [7:0] code, input logic pin);
        if (dev[2:0] == 3'b100 && dev[3] == pin && ch >= 1 && ch <= 6)
            model[ch] = code;
    endtask

    initial begin
        for (int c = 1; c <= 6; c++) model[c] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check_all("R8 reset state");

        // R3/R4/R10 sweep: every channel number, both pin levels, every device code
        for (int p = 0; p < 2; p++) begin
            sel_pin = p[0];
            tick(4);
            for (int ch = 0; ch < 8; ch++) begin
                for (int d = 0; d < 16; d++) begin
                    logic [7:0] code;
                    code = 8'((ch * 37 + d * 11 + p * 101 + 5) & 255);
                    send_frame(d[3:0], ch[2:0], code);
                    pulse_strobe();
                    model_write(d[3:0], ch[2:0], code, p[0]);
                    check_all("R4 R3 R10 sweep");
                end
            end
        end

        // R2: every code value with weights 2^0..2^7, valid device code, pin=1
        for (int v = 0; v < 256; v++) begin
            int c;
            c = (v % 6) + 1;
            send_frame(4'b1100, c[2:0], v[7:0]);
            pulse_strobe();
            model[c] = v[7:0];
            check8("R2 code sweep", c, model[c]);
        end

        // R6: latency of three edges after strobe rises
        send_frame(4'b1100, 3'd2, 8'h5A);
        ser_strobe = 1'b1;
        tick(2);
        check8("R6 not before third edge", 2, model[2]);
        tick(1);
        model[2] = 8'h5A;
        check8("R6 on third edge", 2, 8'h5A);
        tick(3);
        ser_strobe = 1'b0; tick(4);

        // R5: shifting a new frame while strobe held high writes nothing
        send_frame(4'b1100, 3'd4, 8'h3C);
        ser_strobe = 1'b1; tick(4);
        model[4] = 8'h3C;
        send_frame(4'b1100, 3'd5, 8'hC3);
        tick(4);
        check_all("R5 held strobe");
        ser_strobe = 1'b0; tick(4);
        check_all("R5 strobe release");
        pulse_strobe();
        model[5] = 8'hC3;
        check_all("R5 next pulse writes");

        // R9: shift edge and strobe edge in the same cycle use the old frame
        send_frame(4'b1100, 3'd6, 8'hA7);
        ser_data = 1'b1; tick(3);
        ser_clk = 1'b1; ser_strobe = 1'b1;
        tick(4);
        model[6] = 8'hA7;
        check_all("R9 shift and load together");
        ser_clk = 1'b0; ser_strobe = 1'b0; tick(4);

        // R7: plain fault pulse clears everything
        pwr_fail = 1'b1; tick(1);
        for (int c = 1; c <= 6; c++) model[c] = 8'h00;
        check_all("R7 fault clear");
        pwr_fail = 1'b0; tick(2);

        // R7: fault in the same cycle as the strobe edge discards the write
        send_frame(4'b1100, 3'd1, 8'h77);
        send_frame(4'b1100, 3'd1, 8'h77);
        pulse_strobe();
        model[1] = 8'h77;
        check8("R7 pre-fault write", 1, 8'h77);
        send_frame(4'b1100, 3'd3, 8'h99);
        ser_strobe = 1'b1;
        tick(2);
        pwr_fail = 1'b1; tick(1);
        pwr_fail = 1'b0;
        for (int c = 1; c <= 6; c++) model[c] = 8'h00;
        check_all("R7 fault wins over load");
        tick(4);
        check_all("R7 no late write");
        ser_strobe = 1'b0; tick(4);

        // R8: reset clears channels and frame; a bare strobe then writes nothing
        send_frame(4'b1100, 3'd2, 8'h11);
        pulse_strobe();
        model[2] = 8'h11;
        check8("R8 pre-reset write", 2, 8'h11);
        send_frame(4'b1100, 3'd2, 8'h22);
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(2);
        for (int c = 1; c <= 6; c++) model[c] = 8'h00;
        check_all("R8 reset clears");
        pulse_strobe();
        check_all("R8 empty frame no write");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule